// File: doc/BRIEF.md
# Eight-Channel Phase-Offset PWM Bank

This block produces the drive bits for eight high-side switch channels. Each channel either holds a static level taken from a per-channel level bit, or produces a pulse train. Every pulse train is timed by one of two shared 8-bit base counters, and each channel picks its counter with its own select bit. Each base counter steps once for each one-cycle tick strobe on its own external tick input. A full pulse period is therefore 256 ticks of the chosen counter. Each channel has its own 8-bit width value and its own 8-bit start offset. Giving channels different offsets spreads their turn-on edges across the period, so their inrush currents do not coincide.

Each base counter has its own watchdog. When its external tick strobes stop arriving, or come too far apart, the counter goes on stepping from an internal tick generator. It returns to the external strobes once they are seen to be steady again. Width and offset values reach the compare logic only when the channel's counter wraps. A global enable, together with the synchronous reset, releases all eight outputs. The enclosing chip uses this to enter its safe state or perform a software reset.

Top module: `pwm_bank`

## Requirements
- R1: The bank has NCH (default 8) channels, each with its own 8-bit width and 8-bit offset field; channel c uses bits [8c+7:8c] of `duty` and of `phase`.
- R2: When bit c of `pwm_mode` is 0, `drive[c]` follows bit c of `steady_on` (1 = on).
- R3: Bit c of `clk_sel` picks base counter 0 (value 0) or base counter 1 (value 1) for channel c. Counter s is an 8-bit count that steps by one on each clock in which `ext_tick[s]` is 1 and wraps from 255 to 0.
- R4: In pulse mode `drive[c]` is 1 exactly when ((count − offset) mod 256) < width. A width of 0 keeps the channel off, and the pulse starts at the count equal to the offset.
- R5: Width and offset are held in per-channel shadow copies. These copies load from the inputs only in the clock in which the channel's selected counter steps from 255 to 0, and they reset to 0.
- R6: When counter s sees no tick on `ext_tick[s]` for LOSS_LIMIT consecutive clocks, it steps on an internal tick that occurs once every INT_DIV clocks instead. A gap shorter than LOSS_LIMIT causes no change.
- R7: A counter running on the internal tick returns to its external ticks after one external tick followed by two more, each arriving fewer than LOSS_LIMIT clocks after the one before.
- R8: While `rst_n` is 0, and one clock after `out_en` is 0, every bit of `drive` is 0.
- R9: `drive` is registered: it reflects the counter value and the inputs one clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| out_en | input | 1 | 1 lets channels drive; 0 forces all outputs off |
| pwm_mode | input | NCH | Per channel: 1 = pulse mode, 0 = static level |
| clk_sel | input | NCH | Per channel base counter choice (0 or 1) |
| steady_on | input | NCH | Per channel static level used in static mode |
| duty | input | NCH*8 | Packed per-channel pulse widths |
| phase | input | NCH*8 | Packed per-channel start offsets |
| ext_tick | input | 2 | One-clock tick strobes for base counters 0 and 1 |
| drive | output | NCH | Channel drive bits, 1 = switch on |

## Verification
Suppose a base counter steps on the wrong tick source or skips a tick. The channels on that counter then show pulses whose edges are off from the expected counts, and this is visible on the very next tick that crosses a width or offset boundary. A shadow copy that loads early or late changes a pulse edge within the same period, before the next wrap. A watchdog that trips too soon, or stays tripped, shows up as pulse edges appearing at the internal tick rate. Within one internal period the number of output transitions is then far larger or smaller than the external tick count allows.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the compare helper for the PWM bank.
// Assumes the period is fixed at 256 ticks, so the count width is 8.
package pwm_bank_pkg;
    localparam int CNT_W = 8;
    localparam int NSRC  = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    // True while the count lies inside the channel's on-window.
    function automatic logic in_window(cnt_t cnt, cnt_t offs, cnt_t width);
        cnt_t rel;
        rel = cnt_t'(cnt - offs);
        return rel < width;
    endfunction
endpackage

// File: rtl/pwm_int_tick.sv
`timescale 1ns/1ps
// Internal fallback tick: one-cycle pulse every DIV system clocks.
// Assumes DIV >= 2.
module pwm_int_tick #(
    parameter int DIV = 8000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Free-running divider that restarts after its last count.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/pwm_base_src.sv
`timescale 1ns/1ps
// One base counter with its tick watchdog.
// It steps on the external strobe while that strobe is healthy, and on the
// internal tick after LIMIT idle clocks. It comes back after a reference
// tick plus two in-range ticks. Assumes LIMIT >= 2.
module pwm_base_src
    import pwm_bank_pkg::*;
#(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tick,
    input  logic int_tick,
    output cnt_t cnt,
    output logic wrap,
    output logic lost
);
    localparam int GW = $clog2(LIMIT + 1);
    localparam logic [GW-1:0] LIM = GW'(LIMIT);

    logic [GW-1:0] gap_q;
    logic          lost_q;
    logic          good_q;
    cnt_t          cnt_q;
    logic          adv;
    logic          in_range;

    assign adv      = lost_q ? int_tick : ext_tick;
    assign in_range = (gap_q < LIM);

    // Clocks since the last external tick, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)          gap_q <= '0;
        else if (ext_tick)   gap_q <= '0;
        else if (gap_q != LIM) gap_q <= gap_q + 1'b1;
    end

    // Loss flag and count of consecutive in-range ticks while lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_q <= 1'b0;
            good_q <= 1'b0;
        end else if (!lost_q) begin
            good_q <= 1'b0;
            if (!ext_tick && gap_q == LIM - 1'b1) lost_q <= 1'b1;
        end else if (ext_tick) begin
            if (!in_range)   good_q <= 1'b0;
            else if (good_q) begin
                lost_q <= 1'b0;
                good_q <= 1'b0;
            end else         good_q <= 1'b1;
        end
    end

    // The 8-bit base count itself.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = adv && (cnt_q == '1);
    assign lost = lost_q;
endmodule

// File: rtl/pwm_lane.sv
`timescale 1ns/1ps
// One output channel: shadowed width/offset, compare, registered drive.
// Assumes cnt and wrap come from the counter this channel has selected.
module pwm_lane
    import pwm_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t cnt,
    input  logic wrap,
    input  cnt_t width_in,
    input  cnt_t offs_in,
    input  logic mode,
    input  logic level,
    input  logic out_en,
    output logic drive
);
    cnt_t width_q;
    cnt_t offs_q;

    // Take new width and offset only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
            offs_q  <= '0;
        end else if (wrap) begin
            width_q <= width_in;
            offs_q  <= offs_in;
        end
    end

    // Registered output: static level or window compare, gated by enable.
    always_ff @(posedge clk) begin
        if (!rst_n) drive <= 1'b0;
        else        drive <= out_en && (mode ? in_window(cnt, offs_q, width_q) : level);
    end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
// Eight-channel (NCH) PWM bank with two base counters, per-channel counter
// choice, start offset and shadowed width, and an internal fallback tick.
// Assumes ext_tick strobes are synchronous one-clock pulses.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int LOSS_LIMIT = 1024,
    parameter int INT_DIV    = 8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_en,
    input  logic [NCH-1:0]       pwm_mode,
    input  logic [NCH-1:0]       clk_sel,
    input  logic [NCH-1:0]       steady_on,
    input  logic [NCH*CNT_W-1:0] duty,
    input  logic [NCH*CNT_W-1:0] phase,
    input  logic [NSRC-1:0]      ext_tick,
    output logic [NCH-1:0]       drive
);
    logic            int_tick;
    cnt_t            src_cnt  [NSRC];
    logic [NSRC-1:0] src_wrap;
    logic [NSRC-1:0] src_lost;

    pwm_int_tick #(.DIV(INT_DIV)) u_int_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (int_tick)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        pwm_base_src #(.LIMIT(LOSS_LIMIT)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .ext_tick (ext_tick[s]),
            .int_tick (int_tick),
            .cnt      (src_cnt[s]),
            .wrap     (src_wrap[s]),
            .lost     (src_lost[s])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (src_cnt[clk_sel[c]]),
            .wrap     (src_wrap[clk_sel[c]]),
            .width_in (duty[c*CNT_W +: CNT_W]),
            .offs_in  (phase[c*CNT_W +: CNT_W]),
            .mode     (pwm_mode[c]),
            .level    (steady_on[c]),
            .out_en   (out_en),
            .drive    (drive[c])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
// Property checker for pwm_bank, attached by bind below.
// It keeps its own idle counters for the watchdog windows.
module pwm_bank_chk #(
    parameter int NCH        = 8,
    parameter int LOSS_LIMIT = 1024
) (
    input logic           clk,
    input logic           rst_n,
    input logic           out_en,
    input logic [NCH-1:0] pwm_mode,
    input logic [NCH-1:0] steady_on,
    input logic [1:0]     ext_tick,
    input logic [NCH-1:0] drive,
    input logic [1:0]     lost
);
    localparam int IW = $clog2(LOSS_LIMIT + 2);
    localparam logic [IW-1:0] ILIM = IW'(LOSS_LIMIT);

    assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (drive == '0));

    assert_static_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && pwm_mode == '0) |=> (drive == $past(steady_on)));

    for (genvar s = 0; s < 2; s++) begin : g_src_chk
        logic [IW-1:0] idle_q;

        // Independent count of clocks without an external tick.
        always_ff @(posedge clk) begin
            if (!rst_n)            idle_q <= '0;
            else if (ext_tick[s])  idle_q <= '0;
            else if (idle_q != ILIM) idle_q <= idle_q + 1'b1;
        end

        assert_loss_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lost[s]) |-> (idle_q >= ILIM));

        assert_loss_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (lost[s] && !ext_tick[s]) |=> lost[s]);

        assert_recover_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lost[s]) |-> $past(ext_tick[s]));
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .LOSS_LIMIT(LOSS_LIMIT)) u_pwm_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en    (out_en),
    .pwm_mode  (pwm_mode),
    .steady_on (steady_on),
    .ext_tick  (ext_tick),
    .drive     (drive),
    .lost      (src_lost)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
    localparam int NCH = 8;
    localparam int LL  = 20;
    localparam int DIV = 4;

    typedef struct packed {
        logic [7:0]  mode;
        logic [7:0]  sel;
        logic [7:0]  lvl;
        logic [7:0]  dbase;
        logic [7:0]  pstep;
        logic [15:0] nsteps;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 16'd4},
        '{8'hFF, 8'h00, 8'h00, 8'h40, 8'h20, 16'd600},
        '{8'hFF, 8'hF0, 8'h00, 8'h10, 8'h30, 16'd600},
        '{8'h0F, 8'hAA, 8'hF0, 8'h00, 8'h11, 16'd600}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           out_en = 1'b1;
    logic [NCH-1:0] pwm_mode = '0;
    logic [NCH-1:0] clk_sel = '0;
    logic [NCH-1:0] steady_on = '1;
    logic [NCH*8-1:0] duty = '0;
    logic [NCH*8-1:0] phase = '0;
    logic [1:0]     ext_tick = '0;
    logic [NCH-1:0] drive;

    int   n_checks = 0;
    int   n_fail = 0;
    logic par = 1'b0;
    logic [7:0] mc [2];
    logic [7:0] sh_du [NCH];
    logic [7:0] sh_ph [NCH];

    always #2 clk = ~clk;

    pwm_bank #(.NCH(NCH), .LOSS_LIMIT(LL), .INT_DIV(DIV)) i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .pwm_mode(pwm_mode),
        .clk_sel(clk_sel), .steady_on(steady_on), .duty(duty), .phase(phase),
        .ext_tick(ext_tick), .drive(drive)
    );

    task automatic check(input logic got, input logic exp, input string req, input int ch);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d got %b expected %b", req, ch, got, exp);
        end
    endtask

    // Expected drive from the requirement model.
    function automatic logic model_bit(input int c);
        logic [7:0] rel;
        if (!out_en) return 1'b0;
        if (!pwm_mode[c]) return steady_on[c];
        rel = mc[clk_sel[c]] - sh_ph[c];
        return rel < sh_du[c];
    endfunction

    task automatic check_all();
        for (int c = 0; c < NCH; c++)
            check(drive[c], model_bit(c), pwm_mode[c] ? "R1 R3 R4 R5" : "R2 R8", c);
    endtask

    // Pulse the selected tick strobes, update the model, then let outputs settle.
    task automatic tick(input logic [1:0] m);
        ext_tick = m;
        @(negedge clk);
        ext_tick = '0;
        for (int s = 0; s < 2; s++) begin
            if (m[s]) begin
                mc[s] = mc[s] + 8'd1;
                if (mc[s] == 8'd0)
                    for (int c = 0; c < NCH; c++)
                        if (clk_sel[c] == s[0]) begin
                            sh_du[c] = duty[c*8 +: 8];
                            sh_ph[c] = phase[c*8 +: 8];
                        end
            end
        end
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic step();
        tick({par, 1'b1});
        par = ~par;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int edges;
        logic prev;
        mc[0] = 0; mc[1] = 0;
        for (int c = 0; c < NCH; c++) begin sh_du[c] = 0; sh_ph[c] = 0; end

        // Reset state: all outputs released even with static on requested (R8).
        repeat (5) @(negedge clk);
        for (int c = 0; c < NCH; c++) check(drive[c], 1'b0, "R8 reset", c);
        rst_n = 1'b1;
        @(negedge clk);
        // One clock after reset release the static level appears (R9).
        for (int c = 0; c < NCH; c++) check(drive[c], 1'b1, "R9", c);

        // Table walk over configurations.
        for (int i = 0; i < 4; i++) begin
            pwm_mode  = VEC[i].mode;
            clk_sel   = VEC[i].sel;
            steady_on = VEC[i].lvl;
            for (int c = 0; c < NCH; c++) begin
                duty[c*8 +: 8]  = VEC[i].dbase + 8'(16 * c);
                phase[c*8 +: 8] = 8'(VEC[i].pstep * c);
            end
            for (int n = 0; n < int'(VEC[i].nsteps); n++) begin
                step();
                check_all();
            end
        end

        // Global enable low forces everything off (R8).
        out_en = 1'b0;
        step();
        for (int c = 0; c < NCH; c++) check(drive[c], 1'b0, "R8 out_en", c);
        out_en = 1'b1;
        step();
        check_all();

        // Static level latency of one clock (R9, R2).
        pwm_mode  = '0;
        steady_on = 8'h3C;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) check(drive[c], steady_on[c], "R9 R2", c);
        step();

        // Loss of base 1: ch7 pulses on base 1 with half width.
        pwm_mode  = 8'h80;
        clk_sel   = 8'h80;
        duty[7*8 +: 8]  = 8'h80;
        phase[7*8 +: 8] = 8'h00;
        tick(2'b11);
        prev = drive[7];
        repeat (15) @(negedge clk);
        check(drive[7], prev, "R6 short gap", 7);
        edges = 0;
        repeat (2100) begin
            @(negedge clk);
            if (drive[7] != prev) edges++;
            prev = drive[7];
        end
        check(edges >= 2, 1'b1, "R6 fallback", 7);

        // Recovery: reference tick plus two in-range ticks, then slow ticks.
        tick(2'b10);
        tick(2'b10);
        tick(2'b10);
        prev = drive[7];
        edges = 0;
        repeat (128) begin
            ext_tick = 2'b10;
            @(negedge clk);
            ext_tick = '0;
            repeat (15) begin
                @(negedge clk);
                if (drive[7] != prev) edges++;
                prev = drive[7];
            end
        end
        check(edges <= 2, 1'b1, "R7 recovery", 7);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule